// File: doc/BRIEF.md
# Double-Buffered Serial Transmitter with Parity

This block serialises 8-bit characters onto an asynchronous serial line. A single-entry holding register sits in front of the frame shifter, so software or a stream source can hand over the next character while the current one is still going out; the two are sent back to back with no idle bit between them. Bit timing comes from an external baud tick pulse, so the block contains no divisor.

Characters enter through a valid/ready stream port. A character is taken on a clock edge where `in_valid` and `in_ready` are both high. The source must hold `in_valid` and `in_data` steady until that edge. While `in_ready` is low, an offered character is not taken and nothing changes. Once the holding register is filled, `in_ready` stays low until that character moves into the shifter. A character that arrives while the shifter is idle goes straight into the shifter, and `in_ready` stays high. `tx_empty` reports that the whole path has drained. The parity mode is sampled when a character enters the shifter.

Top module: `uart_tx_dbuf`

## Requirements
- R1: A frame on `txd` consists of one low start bit, then the 8 data bits with the least significant bit first, then an optional parity bit, then one high stop bit. With no parity the frame is 10 bits long.
- R2: The `par_mode` codes are 0 = no parity, 1 = even, 2 = odd, 3 = parity bit forced to 0, and 4 = parity bit forced to 1. Codes 5 to 7 act as code 0. Even parity makes the number of ones across the data and parity bits even. Odd parity makes that number odd.
- R3: Each frame bit is held on `txd` for exactly one baud tick period. The start bit begins on the first tick edge after the character enters the shifter.
- R4: `in_ready` is high whenever `tx_en` is high and the holding register is empty. A character accepted while the shifter is idle passes straight to the shifter, and `in_ready` stays high.
- R5: A character accepted while a frame is in flight fills the holding register, and `in_ready` goes low. The character moves to the shifter on the tick edge that ends the current stop bit. On that same edge `in_ready` rises, and the start bit of the next frame follows with no idle time.
- R6: A character offered while `in_ready` is low is not taken. It never appears on the line and does not replace the held character.
- R7: `tx_empty` is high only when the holding register and the shifter are both empty. Once a frame is in flight, it rises only after the last stop bit has fully finished.
- R8: `txd` is high whenever no frame is in flight.
- R9: Driving `tx_en` low clears the holding register and the shifter. While `tx_en` is low, `txd` is high, `in_ready` is low and `tx_empty` is high. No cleared character is sent after `tx_en` returns high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tx_en | input | 1 | Transmitter enable; low clears the path |
| par_mode | input | 3 | Parity mode code (see R2) |
| baud_tick | input | 1 | One-cycle pulse per bit period |
| in_valid | input | 1 | Stream source offers a character |
| in_data | input | 8 | Character to send |
| in_ready | output | 1 | Holding register can take a character |
| tx_empty | output | 1 | Holding register and shifter both empty |
| txd | output | 1 | Serial line, idles high |

## Verification
Single characters are sent under every parity code. The data patterns are chosen so that the even and odd parity results differ, and the forced space and forced mark bits oppose the data bits around them. These runs separate a wrong bit order, a wrong parity sense and a wrong frame length. A back-to-back pair, with a third offer made while the holding register is full, separates direct loading from buffered loading. The same run shows whether the ready flag is released at the right point, whether frames follow each other with no gap, and whether a rejected character stays off the line. A disable in the middle of a frame checks that the path is cleared and that nothing is sent after re-enable.

// File: rtl/utx_pkg.sv
package utx_pkg;
  typedef enum logic [2:0] {
    PAR_NONE  = 3'd0,
    PAR_EVEN  = 3'd1,
    PAR_ODD   = 3'd2,
    PAR_SPACE = 3'd3,
    PAR_MARK  = 3'd4
  } par_mode_e;

  typedef enum logic [1:0] {
    SH_IDLE  = 2'd0,
    SH_WAIT  = 2'd1,
    SH_SHIFT = 2'd2
  } sh_state_e;
endpackage

// File: rtl/utx_parity.sv
module utx_parity #(
  parameter int DW = 8
) (
  input  logic [DW-1:0] data,
  input  logic [2:0]    mode,
  output logic          par_en,
  output logic          par_bit
);
  import utx_pkg::*;

  always_comb begin
    par_en  = 1'b1;
    par_bit = 1'b1;
    case (par_mode_e'(mode))
      PAR_EVEN:  par_bit = ^data;
      PAR_ODD:   par_bit = ~^data;
      PAR_SPACE: par_bit = 1'b0;
      PAR_MARK:  par_bit = 1'b1;
      default:   par_en  = 1'b0;
    endcase
  end
endmodule

// File: rtl/utx_hold.sv
module utx_hold #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          push,
  input  logic          pop,
  input  logic [DW-1:0] din,
  output logic          full,
  output logic [DW-1:0] dout
);
  always_ff @(posedge clk) begin
    if (!rst_n || clr) begin
      full <= 1'b0;
      dout <= '0;
    end else if (push) begin
      full <= 1'b1;
      dout <= din;
    end else if (pop) begin
      full <= 1'b0;
    end
  end

  // R6: a full holding register keeps its character until it is popped
  assert_no_overwrite_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (full && !pop && !clr) |=> (full && $stable(dout)));
endmodule

// File: rtl/utx_shifter.sv
module utx_shifter #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          tick,
  input  logic          ld,
  input  logic [DW-1:0] ld_data,
  input  logic          par_en,
  input  logic          par_bit,
  output logic          ld_ok,
  output logic          busy,
  output logic          txd_o
);
  import utx_pkg::*;

  localparam int FW = DW + 3;
  localparam int IW = $clog2(FW);
  localparam logic [IW-1:0] LAST_PAR  = IW'(FW - 1);
  localparam logic [IW-1:0] LAST_NONE = IW'(FW - 2);

  sh_state_e     state;
  logic [FW-1:0] frame;
  logic [IW-1:0] idx;
  logic [IW-1:0] last;
  logic          at_end;

  assign at_end = (state == SH_SHIFT) && tick && (idx == last);
  assign ld_ok  = (state == SH_IDLE) || at_end;
  assign busy   = (state != SH_IDLE);
  assign txd_o  = (state == SH_SHIFT) ? frame[idx] : 1'b1;

  always_ff @(posedge clk) begin
    if (!rst_n || clr) begin
      state <= SH_IDLE;
      frame <= '1;
      idx   <= '0;
      last  <= LAST_NONE;
    end else if (ld) begin
      frame <= {1'b1, (par_en ? par_bit : 1'b1), ld_data, 1'b0};
      last  <= par_en ? LAST_PAR : LAST_NONE;
      idx   <= '0;
      state <= (state == SH_IDLE) ? SH_WAIT : SH_SHIFT;
    end else if (tick) begin
      case (state)
        SH_WAIT:  begin
          state <= SH_SHIFT;
          idx   <= '0;
        end
        SH_SHIFT: begin
          if (idx == last) state <= SH_IDLE;
          else             idx   <= idx + 1'b1;
        end
        default: state <= SH_IDLE;
      endcase
    end
  end

  // R3: the line only changes on a baud tick edge (or a clear)
  assert_hold_between_ticks_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !clr) |=> $stable(txd_o));
  // R1: the final bit of every frame is a high stop bit
  assert_stop_high_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (state == SH_SHIFT && idx == last) |-> txd_o);
endmodule

// File: rtl/uart_tx_dbuf.sv
module uart_tx_dbuf #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tx_en,
  input  logic [2:0]    par_mode,
  input  logic          baud_tick,
  input  logic          in_valid,
  input  logic [DW-1:0] in_data,
  output logic          in_ready,
  output logic          tx_empty,
  output logic          txd
);
  logic          hold_full;
  logic [DW-1:0] hold_data;
  logic          sh_ldok, sh_busy, sh_ld;
  logic          in_fire, push, pop;
  logic [DW-1:0] ld_data;
  logic          p_en, p_bit;

  assign in_ready = tx_en && !hold_full;
  assign in_fire  = in_valid && in_ready;
  assign push     = in_fire && !sh_ldok;
  assign pop      = tx_en && hold_full && sh_ldok;
  assign sh_ld    = tx_en && sh_ldok && (hold_full || in_fire);
  assign ld_data  = hold_full ? hold_data : in_data;
  assign tx_empty = !tx_en || (!sh_busy && !hold_full);

  utx_hold #(.DW(DW)) u_hold (
    .clk(clk), .rst_n(rst_n), .clr(!tx_en), .push(push), .pop(pop),
    .din(in_data), .full(hold_full), .dout(hold_data)
  );

  utx_parity #(.DW(DW)) u_par (
    .data(ld_data), .mode(par_mode), .par_en(p_en), .par_bit(p_bit)
  );

  utx_shifter #(.DW(DW)) u_shift (
    .clk(clk), .rst_n(rst_n), .clr(!tx_en), .tick(baud_tick), .ld(sh_ld),
    .ld_data(ld_data), .par_en(p_en), .par_bit(p_bit),
    .ld_ok(sh_ldok), .busy(sh_busy), .txd_o(txd)
  );

  // R9: a low enable leaves both stages empty on the next cycle
  assert_disable_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_en |=> (!hold_full && !sh_busy));
  // R7/R8: an empty path never drives a low line
  assert_empty_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_empty && tx_en) |-> txd);
  // R5: a character buffered behind a busy shifter drops ready
  assert_ready_drop_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (in_fire && !sh_ldok && tx_en) |=> !in_ready);
endmodule

// File: tb/uart_tx_dbuf_bench.sv
module uart_tx_dbuf_bench;
  localparam int CLK_PERIOD = 10;
  localparam int TICK_DIV   = 4;
  localparam int NVEC       = 8;
  // {mode[2:0], data[7:0], frame[10:0] (bit0 first on line), len[3:0]}
  localparam logic [25:0] VECS [0:NVEC-1] = '{
    {3'd0, 8'h55, 11'h2AA, 4'd10},
    {3'd1, 8'h55, 11'h4AA, 4'd11},
    {3'd2, 8'h55, 11'h6AA, 4'd11},
    {3'd1, 8'h07, 11'h60E, 4'd11},
    {3'd2, 8'h07, 11'h40E, 4'd11},
    {3'd3, 8'hFF, 11'h5FE, 4'd11},
    {3'd4, 8'h00, 11'h600, 4'd11},
    {3'd5, 8'hA3, 11'h346, 4'd10}
  };

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tx_en = 1'b0;
  logic [2:0] par_mode = 3'd0;
  logic       baud_tick = 1'b0;
  logic       in_valid = 1'b0;
  logic [7:0] in_data = 8'h00;
  logic       in_ready, tx_empty, txd;
  int n_tests = 0;
  int n_fail  = 0;

  uart_tx_dbuf u_uart_tx_dbuf (
    .clk(clk), .rst_n(rst_n), .tx_en(tx_en), .par_mode(par_mode),
    .baud_tick(baud_tick), .in_valid(in_valid), .in_data(in_data),
    .in_ready(in_ready), .tx_empty(tx_empty), .txd(txd)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  initial begin : tick_gen
    int cnt = 0;
    forever begin
      @(posedge clk);
      #1;
      cnt = (cnt + 1) % TICK_DIV;
      baud_tick = (cnt == 0);
    end
  end

  task automatic chk(input bit c, input string tag, input int act, input int exp);
    n_tests++;
    if (!c) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  endtask

  task automatic write_char(input logic [7:0] d);
    @(negedge clk);
    in_valid = 1'b1;
    in_data  = d;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic recv(input int len, input bit imm, output logic [10:0] bits,
                      output bit stable_ok, output bit imm_ok);
    int got = 0;
    int waited = 0;
    bit inb = 0;
    bit newbit = 0;
    logic cur = 1'b1;
    bits = '1;
    stable_ok = 1'b1;
    imm_ok = 1'b1;
    while (got < len) begin
      @(negedge clk);
      if (!inb) begin
        waited++;
        if (waited > 400) got = len;
        else if (baud_tick) begin
          if (txd == 1'b0) begin
            inb = 1; bits[0] = 1'b0; got = 1; newbit = 1;
          end else if (imm) imm_ok = 1'b0;
        end
      end else begin
        if (newbit) begin cur = txd; newbit = 0; end
        else if (txd !== cur) stable_ok = 1'b0;
        if (baud_tick) begin bits[got] = txd; got++; newbit = 1; end
      end
    end
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog: actual %0h expected %0h", 1, 0);
    finish_run();
  end

  initial begin : main
    logic [10:0] rx;
    logic [10:0] mask;
    bit st, im;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // reset state, transmitter disabled (R9, R8)
    chk(txd == 1'b1, "R8 idle line after reset", txd, 1);
    chk(in_ready == 1'b0, "R9 ready low while disabled", in_ready, 0);
    chk(tx_empty == 1'b1, "R9 empty high while disabled", tx_empty, 1);
    tx_en = 1'b1;
    @(negedge clk);
    chk(in_ready == 1'b1, "R4 ready after enable", in_ready, 1);
    chk(tx_empty == 1'b1, "R7 empty after enable", tx_empty, 1);

    // vector table: R1, R2, R3, R7, R8
    for (int i = 0; i < NVEC; i++) begin
      @(negedge clk);
      par_mode = VECS[i][25:23];
      write_char(VECS[i][22:15]);
      recv(int'(VECS[i][3:0]), 1'b0, rx, st, im);
      mask = (VECS[i][3:0] == 4'd10) ? 11'h3FF : 11'h7FF;
      chk((rx & mask) == VECS[i][14:4], "R1/R2 frame bits", int'(rx & mask), int'(VECS[i][14:4]));
      chk(st, "R3 bit held one tick period", st, 1);
      @(negedge clk);
      chk(tx_empty == 1'b1 && txd == 1'b1, "R7/R8 drained after frame", {tx_empty, txd}, 3);
    end

    // back-to-back with a rejected third offer: R4, R5, R6, R7
    par_mode = 3'd0;
    repeat (8) @(negedge clk);
    write_char(8'h3C);
    chk(in_ready == 1'b1, "R4 direct load keeps ready", in_ready, 1);
    chk(tx_empty == 1'b0, "R7 not empty while loaded", tx_empty, 0);
    write_char(8'hE1);
    chk(in_ready == 1'b0, "R5 ready low with held char", in_ready, 0);
    write_char(8'h99);
    chk(in_ready == 1'b0, "R6 ready still low after rejected offer", in_ready, 0);
    recv(10, 1'b0, rx, st, im);
    chk(rx[9:0] == 10'h278, "R5 first frame", int'(rx[9:0]), 'h278);
    @(negedge clk);
    chk(in_ready == 1'b1, "R5 ready back at transfer", in_ready, 1);
    chk(tx_empty == 1'b0, "R7 not empty during second frame", tx_empty, 0);
    recv(10, 1'b1, rx, st, im);
    chk(im, "R5 no gap between frames", im, 1);
    chk(rx[9:0] == 10'h3C2, "R6 held char not overwritten", int'(rx[9:0]), 'h3C2);
    chk(tx_empty == 1'b0, "R7 empty low during last stop bit", tx_empty, 0);
    @(negedge clk);
    chk(tx_empty == 1'b1, "R7 empty after last stop bit", tx_empty, 1);
    begin
      bit low_seen = 0;
      repeat (60) begin
        @(negedge clk);
        if (txd == 1'b0) low_seen = 1;
      end
      chk(!low_seen, "R6 rejected char never sent", low_seen, 0);
    end

    // disable mid-frame: R9
    write_char(8'hC3);
    repeat (14) @(negedge clk);
    tx_en = 1'b0;
    @(negedge clk);
    chk(txd == 1'b1, "R9 line high when disabled", txd, 1);
    chk(in_ready == 1'b0, "R9 ready low when disabled", in_ready, 0);
    chk(tx_empty == 1'b1, "R9 empty high when disabled", tx_empty, 1);
    write_char(8'h0F);
    tx_en = 1'b1;
    @(negedge clk);
    chk(in_ready == 1'b1 && tx_empty == 1'b1, "R9 clean after re-enable", {in_ready, tx_empty}, 3);
    begin
      bit low_seen = 0;
      repeat (60) begin
        @(negedge clk);
        if (txd == 1'b0) low_seen = 1;
      end
      chk(!low_seen, "R9 nothing sent after re-enable", low_seen, 0);
    end
    finish_run();
  end
endmodule